// File: doc/BRIEF.md
# Oscillator Clock Supervisor

This block supervises an external oscillator clock from a free-running reference clock. A coarse timeout monitor notices when oscillator edges stop arriving. Depending on a configuration input, it then either requests that the clock system fall back to self-clocking, or it emits a one-cycle system-reset request. A finer quality checker counts oscillator rising edges inside a fixed window of reference cycles and declares the clock good only when enough edges arrive. A wake-up event, a monitor timeout or a software request starts the checker.

Oscillator edges are counted in the oscillator domain by a Gray-coded counter. A two-flop synchroniser carries the counter into the reference domain, where it is decoded. Both the monitor and the window logic work on the decoded count. The oscillator clock must run slower than half the reference clock, so that the synchronised Gray value moves by at most one step per reference cycle.

Top module: `osc_supervisor`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `self_clk_req`, `sys_rst_req`, `chk_busy`, `chk_pass` and `chk_fail` are all low.
- R2: The monitor times out only after `TIMEOUT_CYC` reference cycles pass with no synchronised oscillator edge. Any such edge restarts the count, so an oscillator with an edge spacing well below that limit never causes a timeout.
- R3: With `cfg_reset_mode` = 1, each timeout event produces exactly one `sys_rst_req` pulse, one reference cycle wide. `self_clk_req` stays low.
- R4: With `cfg_reset_mode` = 0, a timeout sets `self_clk_req`. It stays high, through failed checks, until a quality check passes. It is low again within two cycles after that pass. `sys_rst_req` stays low.
- R5: A check passes (`chk_pass` = 1) when at least `REQ_EDGES` oscillator rising edges are counted during its window, and fails (`chk_fail` = 1) otherwise, including when the oscillator is stopped.
- R6: Starting a check clears both result flags. The result of the last completed check then holds unchanged until the next start.
- R7: `chk_busy` is high for exactly `WINDOW_CYC` reference cycles per check. A start request that arrives while it is high is ignored and does not lengthen the window.
- R8: A one-cycle pulse on `wake_evt` or on `sw_start` while idle starts a check.
- R9: A monitor timeout starts a check automatically, in the same cycle that it raises its response.
- R10: `chk_pass` and `chk_fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| osc_clk | input | 1 | Supervised oscillator clock |
| cfg_reset_mode | input | 1 | Timeout response: 1 = reset pulse, 0 = self-clock request |
| wake_evt | input | 1 | Wake-up event pulse, starts a check |
| sw_start | input | 1 | Software check request pulse |
| self_clk_req | output | 1 | Self-clocking mode request, held until a check passes |
| sys_rst_req | output | 1 | One-cycle system reset request |
| chk_busy | output | 1 | Quality check window in progress |
| chk_pass | output | 1 | Sticky: last check reached the edge threshold |
| chk_fail | output | 1 | Sticky: last check fell short of the threshold |

## Verification
Every cycle, the embedded assertions check several properties. The result flags are mutually exclusive, and they hold unchanged while idle. The window counter advances through a start request without restarting. The reset request never lasts two cycles. The self-clock request drops only on a passing check. A monitor timeout starts the checker. The bench must show the parts that depend on real oscillator timing. It sweeps the oscillator period across the threshold and compares pass or fail with the edge count computed from the period. It measures how long after the oscillator stops the timeout arrives, and it walks the self-clock request through a failed and then a passing check.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;
  typedef enum logic {
    RESP_SELF  = 1'b0,
    RESP_RESET = 1'b1
  } resp_mode_e;
endpackage

// File: rtl/osc_cnt_xfer.sv
// Oscillator edge counter with Gray-coded crossing into the reference domain.
module osc_cnt_xfer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_clk,
  output logic [CNT_W-1:0] cnt_o,
  output logic             edge_o
);
  // ---------------- oscillator domain ----------------
  logic [1:0]       orst_q;
  logic [CNT_W-1:0] obin_q;
  logic [CNT_W-1:0] ogray_q;
  logic [CNT_W-1:0] obin_nxt;

  assign obin_nxt = obin_q + 1'b1;

  always_ff @(posedge osc_clk) begin
    orst_q <= {orst_q[0], rst};
  end

  always_ff @(posedge osc_clk) begin
    if (orst_q[1]) begin
      obin_q  <= '0;
      ogray_q <= '0;
    end else begin
      obin_q  <= obin_nxt;
      ogray_q <= obin_nxt ^ (obin_nxt >> 1);
    end
  end

  // ---------------- reference domain ----------------
  logic [CNT_W-1:0] sync1_q, sync2_q;
  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] cnt_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= ogray_q;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    dec[CNT_W-1] = sync2_q[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      dec[i] = dec[i+1] ^ sync2_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else begin
      cnt_q  <= dec;
      prev_q <= cnt_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign edge_o = (cnt_q != prev_q);
endmodule

// File: rtl/osc_timeout_mon.sv
// Coarse edge-timeout monitor with configurable response.
module osc_timeout_mon
  import osc_sup_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       edge_i,
  input  resp_mode_e mode_i,
  input  logic       chk_pass_i,
  output logic       fire_o,
  output logic       self_req_o,
  output logic       rst_req_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC);
  localparam logic [TW-1:0] PRE   = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] tmo_q;
  logic          expire;
  logic          self_q, rstreq_q;

  assign expire = (tmo_q == PRE) && !edge_i;
  assign fire_o = expire;

  always_ff @(posedge clk) begin
    if (rst)                tmo_q <= '0;
    else if (edge_i)        tmo_q <= '0;
    else if (tmo_q != LIMIT) tmo_q <= tmo_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rstreq_q <= 1'b0;
      self_q   <= 1'b0;
    end else begin
      rstreq_q <= expire && (mode_i == RESP_RESET);
      if (expire && (mode_i == RESP_SELF)) self_q <= 1'b1;
      else if (chk_pass_i)                 self_q <= 1'b0;
    end
  end

  assign self_req_o = self_q;
  assign rst_req_o  = rstreq_q;

  // R2
  edge_restart_chk: assert property (@(posedge clk) disable iff (rst)
    edge_i |=> !rst_req_o && !$rose(self_req_o));
  // R3
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);
  // R4
  self_hold_chk: assert property (@(posedge clk) disable iff (rst)
    self_req_o && !chk_pass_i |=> self_req_o);
endmodule

// File: rtl/osc_quality_chk.sv
// Window edge-count quality checker with sticky result.
module osc_quality_chk #(
  parameter int WINDOW_CYC = 64,
  parameter int REQ_EDGES  = 8,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             pass_pulse_o
);
  localparam int WW = $clog2(WINDOW_CYC);
  localparam logic [WW-1:0]    LAST  = WW'(WINDOW_CYC - 1);
  localparam logic [CNT_W-1:0] REQ_V = CNT_W'(REQ_EDGES);

  logic             busy_q, pass_q, fail_q, ppulse_q;
  logic [WW-1:0]    win_q;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] seen;
  logic             good;

  assign seen = cnt_i - base_q;
  assign good = (seen >= REQ_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
      ppulse_q <= 1'b0;
      win_q    <= '0;
      base_q   <= '0;
    end else begin
      ppulse_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          pass_q <= 1'b0;
          fail_q <= 1'b0;
          win_q  <= '0;
          base_q <= cnt_i;
        end
      end else if (win_q == LAST) begin
        busy_q   <= 1'b0;
        pass_q   <= good;
        fail_q   <= !good;
        ppulse_q <= good;
      end else begin
        win_q <= win_q + 1'b1;
      end
    end
  end

  assign busy_o       = busy_q;
  assign pass_o       = pass_q;
  assign fail_o       = fail_q;
  assign pass_pulse_o = ppulse_q;

  // R10
  pass_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && fail_o));
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !start_i |=> $stable(pass_o) && $stable(fail_o));
  // R7
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && (win_q != LAST) |=> busy_o && (win_q == $past(win_q) + 1'b1));
  // R7
  window_end_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && (win_q == LAST) |=> !busy_o);
endmodule

// File: rtl/osc_supervisor.sv
// Oscillator clock supervisor: timeout monitor plus edge-count quality check.
module osc_supervisor
  import osc_sup_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16,
  parameter int WINDOW_CYC  = 64,
  parameter int REQ_EDGES   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_clk,
  input  logic cfg_reset_mode,
  input  logic wake_evt,
  input  logic sw_start,
  output logic self_clk_req,
  output logic sys_rst_req,
  output logic chk_busy,
  output logic chk_pass,
  output logic chk_fail
);
  // oscillator may tick at most every second reference cycle
  localparam int CNT_W = $clog2(WINDOW_CYC / 2 + 1) + 1;

  logic [CNT_W-1:0] osc_cnt;
  logic             osc_edge;
  logic             mon_fire;
  logic             chk_start;
  logic             pass_pulse;
  resp_mode_e       mode;

  assign mode      = resp_mode_e'(cfg_reset_mode);
  assign chk_start = wake_evt | sw_start | mon_fire;

  osc_cnt_xfer #(.CNT_W(CNT_W)) u_xfer (
    .clk     (clk),
    .rst     (rst),
    .osc_clk (osc_clk),
    .cnt_o   (osc_cnt),
    .edge_o  (osc_edge)
  );

  osc_timeout_mon #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
    .clk        (clk),
    .rst        (rst),
    .edge_i     (osc_edge),
    .mode_i     (mode),
    .chk_pass_i (pass_pulse),
    .fire_o     (mon_fire),
    .self_req_o (self_clk_req),
    .rst_req_o  (sys_rst_req)
  );

  osc_quality_chk #(
    .WINDOW_CYC (WINDOW_CYC),
    .REQ_EDGES  (REQ_EDGES),
    .CNT_W      (CNT_W)
  ) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (chk_start),
    .cnt_i        (osc_cnt),
    .busy_o       (chk_busy),
    .pass_o       (chk_pass),
    .fail_o       (chk_fail),
    .pass_pulse_o (pass_pulse)
  );

  // R9
  mon_start_chk: assert property (@(posedge clk) disable iff (rst)
    mon_fire && !chk_busy |=> chk_busy);
endmodule

// File: tb/osc_supervisor_tb.sv
`timescale 1ns/1ps
module osc_supervisor_tb;
  localparam int TMO = 16;
  localparam int WIN = 64;
  localparam int REQ = 8;
  localparam int WIN_NS = WIN * 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_clk = 1'b0;
  logic cfg_reset_mode = 1'b1;
  logic wake_evt = 1'b0;
  logic sw_start = 1'b0;
  logic self_clk_req, sys_rst_req, chk_busy, chk_pass, chk_fail;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int osc_half = 10;
  bit osc_run = 1'b1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always begin
    if (osc_run) begin
      #(osc_half);
      osc_clk = ~osc_clk;
    end else begin
      osc_clk = 1'b0;
      #1;
    end
  end

  osc_supervisor #(.TIMEOUT_CYC(TMO), .WINDOW_CYC(WIN), .REQ_EDGES(REQ)) u_dut (
    .clk(clk), .rst(rst), .osc_clk(osc_clk), .cfg_reset_mode(cfg_reset_mode),
    .wake_evt(wake_evt), .sw_start(sw_start), .self_clk_req(self_clk_req),
    .sys_rst_req(sys_rst_req), .chk_busy(chk_busy), .chk_pass(chk_pass),
    .chk_fail(chk_fail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // start a check via sw_start or wake_evt; returns busy length and reset pulses seen
  task automatic run_check(input bit use_wake, input bit extra_start,
                           output int busy_len, output int rst_seen);
    @(negedge clk);
    if (use_wake) wake_evt = 1'b1; else sw_start = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
    sw_start = 1'b0;
    // R6 R8: start clears flags and raises busy
    check(chk_busy == 1'b1, use_wake ? "R8 wake start" : "R8 sw start", chk_busy, 1);
    check(!chk_pass && !chk_fail, "R6 flags cleared at start", {chk_pass, chk_fail}, 0);
    busy_len = 1;
    rst_seen = 0;
    while (chk_busy) begin
      if (extra_start && busy_len == 10) sw_start = 1'b1;
      @(negedge clk);
      sw_start = 1'b0;
      if (chk_busy) busy_len++;
      if (sys_rst_req) rst_seen++;
    end
  endtask

  task automatic stop_osc();
    @(posedge osc_clk);
    osc_run = 1'b0;
  endtask

  initial begin
    int blen, rseen, n;
    repeat (10) @(negedge clk);
    // R1 during reset
    check({self_clk_req, sys_rst_req, chk_busy, chk_pass, chk_fail} == 5'b0,
          "R1 reset state", {self_clk_req, sys_rst_req, chk_busy, chk_pass, chk_fail}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({self_clk_req, sys_rst_req, chk_busy, chk_pass, chk_fail} == 5'b0,
          "R1 after release", {self_clk_req, sys_rst_req, chk_busy, chk_pass, chk_fail}, 0);

    // R5 sweep of oscillator period against the edge threshold
    for (int p = 12; p <= 60; p += 4) begin
      osc_half = p / 2;
      repeat (40) @(negedge clk);
      run_check(1'b0, (p == 20), blen, rseen);
      check(blen == WIN, "R7 busy length", blen, WIN);
      check(rseen == 0 && !self_clk_req, "R2 no timeout while running", rseen, 0);
      if (WIN_NS >= (REQ + 2) * p)
        check(chk_pass && !chk_fail, "R5 expected pass", {chk_pass, chk_fail}, 2);
      else if (WIN_NS <= (REQ - 2) * p)
        check(!chk_pass && chk_fail, "R5 expected fail", {chk_pass, chk_fail}, 1);
    end
    // R6 sticky result (last period fails)
    repeat (50) @(negedge clk);
    check(!chk_pass && chk_fail, "R6 result held", {chk_pass, chk_fail}, 1);

    // R8 wake-up start, healthy oscillator
    osc_half = 10;
    repeat (40) @(negedge clk);
    run_check(1'b1, 1'b0, blen, rseen);
    check(chk_pass && !chk_fail, "R5 pass after wake", {chk_pass, chk_fail}, 2);

    // R2 R3 R9: stop oscillator in reset mode
    cfg_reset_mode = 1'b1;
    stop_osc();
    n = 0;
    while (!sys_rst_req && n < 80) begin
      @(negedge clk);
      n++;
    end
    check(n >= TMO && n <= TMO + 8, "R2 timeout delay", n, TMO + 4);
    check(chk_busy == 1'b1, "R9 timeout starts check", chk_busy, 1);
    check(self_clk_req == 1'b0, "R3 no self request", self_clk_req, 0);
    @(negedge clk);
    check(sys_rst_req == 1'b0, "R3 pulse width one", sys_rst_req, 0);
    rseen = 0;
    repeat (150) begin
      @(negedge clk);
      if (sys_rst_req) rseen++;
    end
    check(rseen == 0, "R3 one pulse per event", rseen, 0);
    check(!chk_pass && chk_fail, "R5 dead oscillator fails", {chk_pass, chk_fail}, 1);

    // R4: self-clock mode
    osc_run = 1'b1;
    repeat (40) @(negedge clk);
    cfg_reset_mode = 1'b0;
    stop_osc();
    rseen = 0;
    repeat (40) begin
      @(negedge clk);
      if (sys_rst_req) rseen++;
    end
    check(self_clk_req == 1'b1, "R4 self request set", self_clk_req, 1);
    check(rseen == 0, "R4 no reset pulse", rseen, 0);
    while (chk_busy) @(negedge clk);
    check(chk_fail && self_clk_req, "R4 held after failed check", {chk_fail, self_clk_req}, 3);
    osc_run = 1'b1;
    repeat (40) @(negedge clk);
    check(self_clk_req == 1'b1, "R4 held while idle", self_clk_req, 1);
    run_check(1'b0, 1'b0, blen, rseen);
    repeat (2) @(negedge clk);
    check(chk_pass && !self_clk_req, "R4 cleared by pass", {chk_pass, self_clk_req}, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule